// File: doc/BRIEF.md
# Burst Page Programmer for Serial NOR Flash

This block turns a run of processor writes into a memory-mapped flash window into one serial page-program command. It acts only when the controller's write-burst mode bit is set and its software-mode bit is clear. The first accepted write opens a frame on the addressed bank. The frame carries the program opcode, a 24-bit flash offset and the data bytes. Later writes to the next consecutive address, with the same access size, extend the same frame.

A frame closes in one of three cases: the writes stop for a set number of idle cycles, the next address lands on a page boundary, or the write pattern breaks. On close the block raises a write-complete flag, clears the bank's write-mode flag and can raise an interrupt. A burst cannot start unless a write-enable command has first set the bank's write-mode flag. If it is missing, the write is refused and flagged. While the serializer is still shifting earlier data, the bus is held off with a ready signal.

Top module: `bpp_burst_prog`

## Requirements
- R1: Writes are ignored unless `ctl_word` bit 29 (burst) is 1 and bit 28 (software mode) is 0. An ignored write is accepted at once, causes no frame and sets no flag.
- R2: A write that starts a burst on a bank whose write-mode flag is clear sets the refused-write flag, `status_o` bit 10. No chip select is asserted.
- R3: A frame drives exactly one `spi_cs_n` bit low, for the addressed bank. It sends opcode 0x02, then the 24-bit offset most significant byte first, then the data bytes. Data goes least significant byte first, each byte MSB first. `spi_mosi` is stable while `spi_sck` is high.
- R4: Writes to the next consecutive address with the same size extend the open frame. No new opcode or address is sent.
- R5: A write whose address is not the next one, or whose size differs, closes the open frame. It sets the bad-access flag, `status_o` bit 11, and its data is discarded.
- R6: The frame closes on the first idle cycle after the byte just below a page boundary has been sent. `pg_sel` sets the page size: 1 gives 128 bytes, 2 gives 16 bytes, 0 or 3 give 256 bytes.
- R7: Address bits [25:24] pick the bank. A start write is refused with `status_o` bit 11 and no frame in any of these cases: the bank's enable bit `ctl_word[bank]` is 0, the size code is 3, or the address is not aligned to its size. Size codes: 0 is a byte, 1 a halfword, 2 a word.
- R8: When a frame closes, `status_o` bit 9 is set and the bank's write-mode flag (`status_o` bit 12+bank) is cleared. `irq` equals bit 9 AND `irq_en`.
- R9: If no further write arrives, the frame closes GAP_CYC+1 cycles after the serializer goes idle.
- R10: `wr_ready` is low while the serializer is still shifting earlier bytes of an open frame.
- R11: After reset, all `spi_cs_n` are high, `spi_sck` is low, `status_o` is 0 and `wr_ready` is high.
- R12: A `wel_set[b]` pulse sets `status_o` bit 12+b. `sts_clr` clears bits 9 to 11 and leaves the write-mode flags alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_word | input | 32 | Controller configuration: bit 29 burst, bit 28 software mode, [NBANK-1:0] bank enables |
| pg_sel | input | 2 | Page size select |
| irq_en | input | 1 | Completion interrupt enable |
| sts_clr | input | 1 | Clears the completion and error flags |
| wel_set | input | NBANK | Per-bank pulse from a finished write-enable command |
| wr_valid | input | 1 | Bus write request |
| wr_addr | input | OFS_W+2 | Window address: bank in the top bits, flash offset below |
| wr_size | input | 2 | Access size code |
| wr_data | input | 32 | Write data, byte lanes from bit 0 |
| wr_ready | output | 1 | Write accepted on a clock edge where valid and ready are both high |
| status_o | output | 16 | Flags: bit 9 done, bit 10 refused write, bit 11 bad access, bits 12+ write-mode per bank |
| irq | output | 1 | Completion interrupt |
| spi_sck | output | 1 | Serial clock, one bit every two cycles |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | NBANK | Active-low chip selects |

## Verification
Refusals, the write-mode flag update and the completion flag all change at the same edge that accepts the write or closes the frame. The bench therefore reads them at the first falling edge after the driver's handshake edge. A frame's chip select falls at the edge that accepts its first write. It rises GAP_CYC+1 cycles after the last serial bit, or one cycle after it when a page boundary closes the frame. A serial monitor counts the low-clock samples that follow the last bit and compares that count with those two figures. Stall cycles are counted in the write driver, so R10 shows up as a nonzero wait on a back-to-back write.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } acc_size_e;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_SEND = 1'b1
   } prog_state_e;

   localparam logic [7:0] PROG_OPC      = 8'h02;
   localparam int         CTL_BURST_BIT = 29;
   localparam int         CTL_SW_BIT    = 28;
   localparam int         ST_DONE       = 9;
   localparam int         ST_NOWEL      = 10;
   localparam int         ST_BADACC     = 11;
   localparam int         ST_WM_BASE    = 12;
endpackage

// File: rtl/bpp_shifter.sv
module bpp_shifter #(
   parameter int MAX_BYTES = 8
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               load_i,
   input  logic [MAX_BYTES*8-1:0]             load_vec_i,
   input  logic [$clog2(MAX_BYTES+1)-1:0]     load_cnt_i,
   output logic                               busy_o,
   output logic                               sck_o,
   output logic                               mosi_o
);
   localparam int VW = MAX_BYTES * 8;
   localparam int CW = $clog2(VW + 1);

   generate
      if (MAX_BYTES < 5) begin : g_bad_depth
         $error("bpp_shifter: MAX_BYTES must hold header plus one byte");
      end
   endgenerate

   logic [VW-1:0] sh_q;
   logic [CW-1:0] bits_q;
   logic          phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         bits_q  <= '0;
         phase_q <= 1'b0;
      end else if (load_i) begin
         sh_q    <= load_vec_i;
         bits_q  <= CW'({load_cnt_i, 3'b000});
         phase_q <= 1'b0;
      end else if (bits_q != '0) begin
         phase_q <= ~phase_q;
         if (phase_q) begin
            sh_q   <= sh_q << 1;
            bits_q <= bits_q - CW'(1);
         end
      end
   end

   assign busy_o = (bits_q != '0);
   assign sck_o  = phase_q;
   assign mosi_o = sh_q[VW-1];

   assert_mosi_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sck_o |-> $stable(mosi_o));
   assert_sck_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !sck_o);
endmodule

// File: rtl/bpp_wm_flags.sv
module bpp_wm_flags #(
   parameter int NBANK = 4,
   localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBANK-1:0] set_i,
   input  logic             clr_i,
   input  logic [BW-1:0]    clr_bank_i,
   output logic [NBANK-1:0] wm_o
);
   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               wm_o[b] <= 1'b0;
            else if (set_i[b])
               wm_o[b] <= 1'b1;
            else if (clr_i && clr_bank_i == BW'(b))
               wm_o[b] <= 1'b0;
         end

         assert_wm_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> wm_o[b]);
      end
   endgenerate
endmodule

// File: rtl/bpp_burst_prog.sv
module bpp_burst_prog
   import bpp_pkg::*;
#(
   parameter int NBANK   = 4,
   parameter int OFS_W   = 24,
   parameter int GAP_CYC = 4,
   localparam int BW     = (NBANK > 1) ? $clog2(NBANK) : 1,
   localparam int ADDR_W = OFS_W + BW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       ctl_word,
   input  logic [1:0]        pg_sel,
   input  logic              irq_en,
   input  logic              sts_clr,
   input  logic [NBANK-1:0]  wel_set,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [1:0]        wr_size,
   input  logic [31:0]       wr_data,
   output logic              wr_ready,
   output logic [15:0]       status_o,
   output logic              irq,
   output logic              spi_sck,
   output logic              spi_mosi,
   output logic [NBANK-1:0]  spi_cs_n
);
   localparam int SH_BYTES = 8;
   localparam int CNTW     = $clog2(SH_BYTES + 1);
   localparam int GW       = $clog2(GAP_CYC + 1);

   generate
      if (NBANK < 1 || NBANK > 4) begin : g_bad_nbank
         $error("bpp_burst_prog: NBANK must be 1 to 4");
      end
      if (OFS_W < 8 || OFS_W > 24) begin : g_bad_ofs
         $error("bpp_burst_prog: OFS_W must be 8 to 24");
      end
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("bpp_burst_prog: GAP_CYC must be at least 1");
      end
   endgenerate

   prog_state_e       state_q;
   logic [BW-1:0]     cur_bank_q;
   logic [ADDR_W-1:0] next_a_q;
   logic [1:0]        cur_size_q;
   logic [GW-1:0]     gap_q;
   logic              cs_act_q;
   logic              done_q, nowel_q, badacc_q;

   logic              mode_on, bank_on, wm_sel, size_ok, aligned, page_end;
   logic [BW-1:0]     wr_bank;
   logic [2:0]        nbytes;
   logic [7:0]        pmask;
   logic [31:0]       dv;
   logic              accept, start, append, finish, rej_nowel, rej_bad;
   logic              sh_busy, load;
   logic [SH_BYTES*8-1:0] load_vec;
   logic [CNTW-1:0]   load_cnt;
   logic [NBANK-1:0]  wm;
   logic              unused_ctl;

   assign unused_ctl = ^{ctl_word[31:30], ctl_word[27:NBANK]};
   assign mode_on    = ctl_word[CTL_BURST_BIT] & ~ctl_word[CTL_SW_BIT];
   assign wr_bank    = wr_addr[ADDR_W-1:OFS_W];
   assign dv         = {wr_data[7:0], wr_data[15:8], wr_data[23:16], wr_data[31:24]};

   always_comb begin
      bank_on = 1'b0;
      wm_sel  = 1'b0;
      for (int i = 0; i < NBANK; i++) begin
         if (wr_bank == BW'(i)) begin
            bank_on = ctl_word[i];
            wm_sel  = wm[i];
         end
      end
   end

   always_comb begin
      size_ok = 1'b1;
      unique case (wr_size)
         SZ_BYTE: begin nbytes = 3'd1; aligned = 1'b1; end
         SZ_HALF: begin nbytes = 3'd2; aligned = ~wr_addr[0]; end
         SZ_WORD: begin nbytes = 3'd4; aligned = (wr_addr[1:0] == 2'b00); end
         default: begin nbytes = 3'd0; aligned = 1'b0; size_ok = 1'b0; end
      endcase
   end

   always_comb begin
      unique case (pg_sel)
         2'd1:    pmask = 8'h7F;
         2'd2:    pmask = 8'h0F;
         default: pmask = 8'hFF;
      endcase
   end
   assign page_end = ((next_a_q[7:0] & pmask) == 8'h00);

   assign wr_ready = (state_q == PH_IDLE) | (~sh_busy & mode_on & ~page_end);
   assign accept   = wr_valid & wr_ready;

   always_comb begin
      start = 1'b0; append = 1'b0; finish = 1'b0;
      rej_nowel = 1'b0; rej_bad = 1'b0;
      if (state_q == PH_IDLE) begin
         if (accept && mode_on) begin
            if (!size_ok || !aligned || !bank_on) rej_bad   = 1'b1;
            else if (!wm_sel)                     rej_nowel = 1'b1;
            else                                  start     = 1'b1;
         end
      end else if (!sh_busy) begin
         if (accept) begin
            if (wr_addr == next_a_q && wr_size == cur_size_q) append = 1'b1;
            else begin
               finish  = 1'b1;
               rej_bad = 1'b1;
            end
         end else if (page_end || !mode_on || gap_q == GW'(GAP_CYC)) begin
            finish = 1'b1;
         end
      end
   end

   assign load     = start | append;
   assign load_vec = start ? {PROG_OPC, 24'(wr_addr[OFS_W-1:0]), dv} : {dv, 32'h0};
   assign load_cnt = start ? CNTW'(4 + nbytes) : CNTW'(nbytes);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= PH_IDLE;
         cur_bank_q <= '0;
         next_a_q   <= '0;
         cur_size_q <= '0;
         gap_q      <= '0;
         cs_act_q   <= 1'b0;
         done_q     <= 1'b0;
         nowel_q    <= 1'b0;
         badacc_q   <= 1'b0;
      end else begin
         if (start) begin
            state_q    <= PH_SEND;
            cur_bank_q <= wr_bank;
            cur_size_q <= wr_size;
            cs_act_q   <= 1'b1;
         end else if (finish) begin
            state_q  <= PH_IDLE;
            cs_act_q <= 1'b0;
         end
         if (load) begin
            next_a_q <= wr_addr + ADDR_W'(nbytes);
            gap_q    <= '0;
         end else if (state_q == PH_SEND && !sh_busy && !finish) begin
            gap_q <= gap_q + GW'(1);
         end
         done_q   <= finish    | (done_q   & ~sts_clr);
         nowel_q  <= rej_nowel | (nowel_q  & ~sts_clr);
         badacc_q <= rej_bad   | (badacc_q & ~sts_clr);
      end
   end

   bpp_shifter #(.MAX_BYTES(SH_BYTES)) u_shift (
      .clk(clk), .rst_n(rst_n), .load_i(load), .load_vec_i(load_vec),
      .load_cnt_i(load_cnt), .busy_o(sh_busy), .sck_o(spi_sck), .mosi_o(spi_mosi));

   bpp_wm_flags #(.NBANK(NBANK)) u_wm (
      .clk(clk), .rst_n(rst_n), .set_i(wel_set), .clr_i(finish),
      .clr_bank_i(cur_bank_q), .wm_o(wm));

   always_comb begin
      status_o            = '0;
      status_o[ST_DONE]   = done_q;
      status_o[ST_NOWEL]  = nowel_q;
      status_o[ST_BADACC] = badacc_q;
      for (int i = 0; i < NBANK; i++) status_o[ST_WM_BASE+i] = wm[i];
      for (int i = 0; i < NBANK; i++) spi_cs_n[i] = ~(cs_act_q && cur_bank_q == BW'(i));
   end
   assign irq = done_q & irq_en;

   assert_one_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~spi_cs_n));
   assert_shift_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sh_busy |-> cs_act_q);
   assert_done_on_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_act_q) |-> status_o[ST_DONE]);
   assert_refuse_no_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nowel_q) |-> !cs_act_q);
   assert_mode_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_IDLE && !mode_on) |=> !cs_act_q);
   assert_bank_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_IDLE && wr_valid && !bank_on) |=> !cs_act_q);
endmodule

// File: tb/bpp_burst_prog_tb_top.sv
module bpp_burst_prog_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int GAP        = 4;
   localparam logic [31:0] CTL_ON = 32'h2000_000F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ctl_word = CTL_ON;
   logic [1:0]  pg_sel = 2'd0;
   logic        irq_en = 1'b0, sts_clr = 1'b0;
   logic [3:0]  wel_set = '0;
   logic        wr_valid = 1'b0;
   logic [25:0] wr_addr = '0;
   logic [1:0]  wr_size = '0;
   logic [31:0] wr_data = '0;
   logic        wr_ready, irq, spi_sck, spi_mosi;
   logic [15:0] status_o;
   logic [3:0]  spi_cs_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   bpp_burst_prog #(.NBANK(4), .OFS_W(24), .GAP_CYC(GAP)) dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .pg_sel(pg_sel),
      .irq_en(irq_en), .sts_clr(sts_clr), .wel_set(wel_set),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_size(wr_size),
      .wr_data(wr_data), .wr_ready(wr_ready), .status_o(status_o),
      .irq(irq), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n));

   int n_chk = 0, n_bad = 0;
   bit done_flag = 0;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // serial monitor
   logic [7:0] cur_fr [0:15];
   logic [7:0] last_fr [0:15];
   logic [7:0] sh_byte;
   int cur_n, bitc, tail, cur_bk;
   int last_n, last_bank, last_tail, nframes;
   logic prev_sck, prev_act, act_now;

   always @(negedge clk) begin
      if (!rst_n) begin
         cur_n = 0; bitc = 0; tail = 0; nframes = 0; cur_bk = -1;
         last_n = 0; last_bank = -1; last_tail = 0;
         prev_sck = 1'b0; prev_act = 1'b0; sh_byte = '0;
      end else begin
         act_now = (spi_cs_n != 4'hF);
         if (act_now) begin
            for (int i = 0; i < 4; i++) if (!spi_cs_n[i]) cur_bk = i;
            if (spi_sck && !prev_sck) begin
               sh_byte = {sh_byte[6:0], spi_mosi};
               bitc++;
               if (bitc == 8) begin
                  if (cur_n < 16) cur_fr[cur_n] = sh_byte;
                  cur_n++;
                  bitc = 0;
               end
               tail = 0;
            end else if (!spi_sck) begin
               tail++;
            end
         end else if (prev_act) begin
            for (int i = 0; i < 16; i++) last_fr[i] = cur_fr[i];
            last_n = cur_n; last_bank = cur_bk; last_tail = tail;
            nframes++;
            cur_n = 0; bitc = 0; tail = 0;
         end
         prev_sck = spi_sck;
         prev_act = act_now;
      end
   end

   task automatic do_write(input logic [25:0] a, input logic [1:0] sz,
                           input logic [31:0] d, output int stall);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_size = sz; wr_data = d;
      stall = 0;
      #1;
      while (!wr_ready) begin
         stall++;
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic pulse_wel(input int b);
      @(negedge clk); wel_set[b] = 1'b1;
      @(negedge clk); wel_set = '0;
   endtask

   task automatic clear_sts();
      @(negedge clk); sts_clr = 1'b1;
      @(negedge clk); sts_clr = 1'b0;
   endtask

   task automatic settle();
      repeat (160) @(negedge clk);
   endtask

   task automatic chk_frame(input string req, input logic [127:0] exp, input int n,
                            input int bank, input int fr_before);
      int bad_i;
      chk(req, "frame count", 64'(nframes), 64'(fr_before + 1));
      chk(req, "frame length", 64'(last_n), 64'(n));
      chk(req, "frame bank", 64'(last_bank), 64'(bank));
      bad_i = -1;
      for (int i = 0; i < n && i < 16; i++)
         if (bad_i < 0 && last_fr[i] !== exp[127-8*i -: 8]) bad_i = i;
      if (bad_i >= 0)
         chk(req, $sformatf("frame byte %0d", bad_i), 64'(last_fr[bad_i]),
             64'(exp[127-8*bad_i -: 8]));
      else
         chk(req, "frame bytes", 64'd0, 64'd0);
   endtask

   task automatic t_reset();
      chk("R11", "cs_n after reset", 64'(spi_cs_n), 64'hF);
      chk("R11", "sck after reset", 64'(spi_sck), 64'd0);
      chk("R11", "status after reset", 64'(status_o), 64'd0);
      chk("R11", "ready after reset", 64'(wr_ready), 64'd1);
   endtask

   task automatic t_mode_gate();
      int st, f0;
      pulse_wel(0);
      chk("R12", "wm bank0 set", 64'(status_o), 64'h1000);
      f0 = nframes;
      ctl_word = 32'h0000_000F;
      do_write(26'h0000100, 2'd0, 32'h11, st);
      settle();
      chk("R1", "burst off no frame", 64'(nframes), 64'(f0));
      chk("R1", "burst off status", 64'(status_o), 64'h1000);
      chk("R1", "burst off no stall", 64'(st), 64'd0);
      ctl_word = 32'h3000_000F;
      do_write(26'h0000100, 2'd0, 32'h11, st);
      settle();
      chk("R1", "sw mode no frame", 64'(nframes), 64'(f0));
      chk("R1", "sw mode status", 64'(status_o), 64'h1000);
      ctl_word = CTL_ON;
   endtask

   task automatic t_no_wel();
      int st, f0;
      f0 = nframes;
      do_write({2'd1, 24'h000040}, 2'd0, 32'h22, st);
      chk("R2", "refused write flag", 64'(status_o), 64'h1400);
      settle();
      chk("R2", "refused write no frame", 64'(nframes), 64'(f0));
      clear_sts();
      chk("R12", "clear keeps wm", 64'(status_o), 64'h1000);
   endtask

   task automatic t_single_word();
      int st, f0;
      irq_en = 1'b1;
      f0 = nframes;
      do_write(26'h0000100, 2'd2, 32'hA1B2C3D4, st);
      settle();
      chk_frame("R3", {8'h02, 8'h00, 8'h01, 8'h00, 8'hD4, 8'hC3, 8'hB2, 8'hA1, 64'h0}, 8, 0, f0);
      chk("R9", "idle close tail", 64'(last_tail), 64'(GAP + 1));
      chk("R8", "done set wm cleared", 64'(status_o), 64'h0200);
      chk("R8", "irq with enable", 64'(irq), 64'd1);
      irq_en = 1'b0;
      #1;
      chk("R8", "irq masked", 64'(irq), 64'd0);
      clear_sts();
   endtask

   task automatic t_halfword_burst();
      int st1, st2, st3, f0;
      pulse_wel(2);
      f0 = nframes;
      do_write({2'd2, 24'h000010}, 2'd1, 32'h1122, st1);
      do_write({2'd2, 24'h000012}, 2'd1, 32'h3344, st2);
      do_write({2'd2, 24'h000014}, 2'd1, 32'h5566, st3);
      chk("R10", "stall while shifting", 64'(st2 > 0), 64'd1);
      settle();
      chk_frame("R4", {8'h02, 8'h00, 8'h00, 8'h10, 8'h22, 8'h11, 8'h44, 8'h33,
                       8'h66, 8'h55, 48'h0}, 10, 2, f0);
      chk("R8", "bank2 close status", 64'(status_o), 64'h0200);
      clear_sts();
   endtask

   task automatic t_page_edge();
      int st, f0;
      pg_sel = 2'd2;
      pulse_wel(0);
      f0 = nframes;
      do_write(26'h000000E, 2'd0, 32'hAA, st);
      do_write(26'h000000F, 2'd0, 32'hBB, st);
      do_write(26'h0000010, 2'd0, 32'hCC, st);
      settle();
      chk_frame("R6", {8'h02, 8'h00, 8'h00, 8'h0E, 8'hAA, 8'hBB, 80'h0}, 6, 0, f0);
      chk("R6", "16-byte page close tail", 64'(last_tail), 64'd1);
      chk("R6", "next write after page refused", 64'(status_o), 64'h0600);
      clear_sts();
      pg_sel = 2'd1;
      pulse_wel(0);
      f0 = nframes;
      do_write(26'h000007C, 2'd2, 32'h04030201, st);
      settle();
      chk_frame("R6", {8'h02, 8'h00, 8'h00, 8'h7C, 8'h01, 8'h02, 8'h03, 8'h04, 64'h0}, 8, 0, f0);
      chk("R6", "128-byte page close tail", 64'(last_tail), 64'd1);
      pg_sel = 2'd0;
      clear_sts();
   endtask

   task automatic t_break();
      int st, f0;
      pulse_wel(0);
      f0 = nframes;
      do_write(26'h0000020, 2'd0, 32'h5A, st);
      do_write(26'h0000022, 2'd0, 32'h6B, st);
      settle();
      chk_frame("R5", {8'h02, 8'h00, 8'h00, 8'h20, 8'h5A, 88'h0}, 5, 0, f0);
      chk("R5", "gap address flags", 64'(status_o), 64'h0A00);
      clear_sts();
      pulse_wel(0);
      f0 = nframes;
      do_write(26'h0000040, 2'd0, 32'h01, st);
      do_write(26'h0000041, 2'd0, 32'h02, st);
      do_write(26'h0000042, 2'd1, 32'h0403, st);
      settle();
      chk_frame("R5", {8'h02, 8'h00, 8'h00, 8'h40, 8'h01, 8'h02, 80'h0}, 6, 0, f0);
      chk("R5", "size change flags", 64'(status_o), 64'h0A00);
      clear_sts();
   endtask

   task automatic t_bank_checks();
      int st, f0;
      ctl_word = 32'h2000_0007;
      pulse_wel(3);
      f0 = nframes;
      do_write({2'd3, 24'h000000}, 2'd0, 32'h77, st);
      chk("R7", "disabled bank flag", 64'(status_o), 64'h8800);
      settle();
      chk("R7", "disabled bank no frame", 64'(nframes), 64'(f0));
      ctl_word = CTL_ON;
      clear_sts();
      pulse_wel(0);
      do_write(26'h0000002, 2'd2, 32'h12345678, st);
      chk("R7", "misaligned word flag", 64'(status_o), 64'h9800);
      settle();
      chk("R7", "misaligned no frame", 64'(nframes), 64'(f0));
      clear_sts();
      do_write(26'h0000000, 2'd3, 32'h0, st);
      chk("R7", "size code 3 flag", 64'(status_o), 64'h9800);
      clear_sts();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mode_gate();
      t_no_wel();
      t_single_word();
      t_halfword_burst();
      t_page_edge();
      t_break();
      t_bank_checks();
      if (!done_flag) begin
         done_flag = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule